// File: doc/BRIEF.md
# Four-Input Priority Interrupt Controller

This block gathers four external interrupt request lines and presents a single interrupt request, with a vector, to a processor core. Software chooses the sensitivity and polarity of each line. A line can be level-sensitive, active high or active low. It can also be edge-sensitive, rising or falling, in which case a latch holds the request. Software also gives each line a 2-bit priority, sets a vector base and decides whether nested servicing is allowed.

When the core acknowledges a presented request, the chosen line moves from pending to in-service. If that line is edge-sensitive, its latch is cleared at the same time. An end-of-interrupt pulse from the core retires the most important routine still in service. While a routine is active, the in-service state decides what may reach the core. With nesting disabled, nothing does. With nesting enabled, only requests of strictly higher priority than the highest routine in service get through.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, int_req and int_vec are 0, every line is level-sensitive and active high, all priorities are 0, nesting is off and the vector base is 0x20.
- R2: A level-sensitive line requests for as long as its pin matches its polarity bit (1 = high active, 0 = low active), seen two clocks after the pin changes.
- R3: An edge-sensitive line latches a request on a rising edge (polarity 1) or a falling edge (polarity 0) of its synchronized pin. The latch holds after the pin returns, ignores the other edge, and is cleared only by the acknowledge that takes that line.
- R4: Among pending lines not in service, the one with the largest priority value is presented, and on equal values the lower line index wins.
- R5: int_vec equals the vector base plus the presented line index (0..3) while int_req is 1, and is 0 otherwise.
- R6: An acknowledge while int_req is 1 puts the presented line in service, and that line stops requesting until it is retired. An acknowledge while int_req is 0 has no effect.
- R7: With nesting off, int_req stays 0 while any line is in service.
- R8: With nesting on, a pending line is forwarded during service only if its priority is strictly greater than the highest priority in service; equal or lower priorities wait.
- R9: An end-of-interrupt pulse clears the in-service bit of the in-service line with the largest priority (lower index on a tie).
- R10: When acknowledge and end-of-interrupt arrive in the same cycle, the end-of-interrupt retires a line chosen from the in-service set before that cycle, and the acknowledged line still enters service.
- R11: Configuration writes with cfg_we: address 0 sets edge mode in bits 3:0 and polarity in bits 7:4, one bit per line; address 1 sets the priority of line i in bits 2i+1:2i; address 2 bit 0 enables nesting; address 3 sets the vector base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pins | input | 4 | Raw asynchronous request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| int_ack | input | 1 | Acknowledge from the core |
| eoi | input | 1 | End-of-interrupt pulse from the core |
| int_req | output | 1 | Interrupt request to the core |
| int_vec | output | 8 | Vector of the presented request |

## Verification
Acknowledge and end-of-interrupt can act in the same cycle. The acknowledge adds a line to the in-service set while the end-of-interrupt removes one from it. The bench provokes this by putting a low-priority line in service, nesting a higher-priority request on top of it, and then raising both strobes together. It judges the outcome at the ports: a later low-priority request must stay blocked until a further end-of-interrupt, which shows the new line entered service and the old one was retired.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 4,
  parameter int PW = 2,
  parameter int VW = 8,
  parameter int WD = 8,
  parameter logic [VW-1:0] VBASE_RST = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    irq_pins,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [WD-1:0] cfg_wdata,
  input  logic          int_ack,
  input  logic          eoi,
  output logic          int_req,
  output logic [VW-1:0] int_vec
);
  localparam int IW = $clog2(NSRC);

  logic [NSRC-1:0] s1, s2, s3, mode, pol, edge_q, isr;
  logic [PW-1:0]   prio [NSRC];
  logic            nest_en;
  logic [VW-1:0]   vbase;

  logic [NSRC-1:0] lvl, det, raw, pend, take_set, eoi_clr;
  logic [IW-1:0]   sel, eoi_idx;
  logic [PW-1:0]   sel_p, cur_p;
  logic            any_p, isr_any, allow, take;

  assign lvl  = ~(s2 ^ pol);
  assign det  = mode & ((pol & s2 & ~s3) | (~pol & ~s2 & s3));
  assign raw  = (mode & edge_q) | (~mode & lvl);
  assign pend = raw & ~isr;

  always_comb begin
    sel = '0; sel_p = '0; any_p = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (pend[i] && (!any_p || prio[i] > sel_p)) begin
        any_p = 1'b1; sel = IW'(i); sel_p = prio[i];
      end
  end

  always_comb begin
    eoi_idx = '0; cur_p = '0; isr_any = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (isr[i] && (!isr_any || prio[i] > cur_p)) begin
        isr_any = 1'b1; eoi_idx = IW'(i); cur_p = prio[i];
      end
  end

  assign allow    = !isr_any || (nest_en && sel_p > cur_p);
  assign int_req  = any_p && allow;
  assign int_vec  = int_req ? vbase + VW'(sel) : '0;
  assign take     = int_ack && int_req;
  assign take_set = take ? (NSRC'(1) << sel) : '0;
  assign eoi_clr  = (eoi && isr_any) ? (NSRC'(1) << eoi_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= irq_pins[NSRC-1:0];
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0; pol <= '1; nest_en <= 1'b0; vbase <= VBASE_RST;
      for (int i = 0; i < NSRC; i++) prio[i] <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: begin mode <= cfg_wdata[NSRC-1:0]; pol <= cfg_wdata[2*NSRC-1:NSRC]; end
        2'd1: for (int i = 0; i < NSRC; i++) prio[i] <= cfg_wdata[i*PW +: PW];
        2'd2: nest_en <= cfg_wdata[0];
        default: vbase <= cfg_wdata[VW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q <= '0;
      isr    <= '0;
    end else begin
      edge_q <= (edge_q & ~take_set) | det;
      isr    <= (isr & ~eoi_clr) | take_set;
    end
  end

  // R4
  sel_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> pend[sel]);

  // R7
  nest_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_en && isr != '0) |-> !int_req);

  // R6
  ack_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_req && !eoi) |=> isr != '0);

  // R6
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_req && !eoi) |=> isr == $past(isr));

  // R9
  eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr != '0 && !take) |=> $countones(isr) == $countones($past(isr)) - 1);

  // R3
  edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q != '0 && !take) |=> (edge_q & $past(edge_q)) == $past(edge_q));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] irq_pins = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic int_ack = 1'b0, eoi = 1'b0;
  logic int_req;
  logic [7:0] int_vec;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .int_ack(int_ack),
    .eoi(eoi), .int_req(int_req), .int_vec(int_vec));

  // {pins, prio byte, expected req, expected index}
  localparam logic [14:0] TBL [8] = '{
    15'b0000_00000000_0_00,
    15'b0001_00000000_1_00,
    15'b1010_00000000_1_01,
    15'b1010_11000000_1_11,
    15'b1111_01101001_1_01,
    15'b0100_01101001_1_10,
    15'b1101_00011011_1_00,
    15'b1100_00011011_1_10
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic ack();
    int_ack = 1'b1; tick(1); int_ack = 1'b0;
  endtask

  task automatic end_irq();
    eoi = 1'b1; tick(1); eoi = 1'b0;
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req, logic r, logic [7:0] v);
    check(req, {7'd0, int_req, int_vec}, {7'd0, r, v});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    tick(3);
    chk_out("R1 reset", 1'b0, 8'h00);
    rst_n = 1'b1;
    tick(2);
    chk_out("R1 after reset", 1'b0, 8'h00);

    // R2 R4 R5 level priority table
    for (int k = 0; k < 8; k++) begin
      wr(2'd1, TBL[k][10:3]);
      irq_pins = TBL[k][14:11];
      tick(3);
      chk_out("R4 table", TBL[k][2], TBL[k][2] ? 8'h20 + {6'd0, TBL[k][1:0]} : 8'h00);
    end
    irq_pins = '0;
    tick(3);

    // R6 R7 R9 nesting off
    wr(2'd1, 8'hC0);
    irq_pins = 4'b0001; tick(3);
    chk_out("R2 level", 1'b1, 8'h20);
    ack(); tick(1);
    chk_out("R6 taken", 1'b0, 8'h00);
    irq_pins = 4'b1001; tick(3);
    chk_out("R7 blocked", 1'b0, 8'h00);
    end_irq();
    chk_out("R9 retire", 1'b1, 8'h23);
    ack(); irq_pins = '0; end_irq(); tick(3);
    chk_out("R9 idle", 1'b0, 8'h00);

    // R6 ack ignored without request
    ack(); irq_pins = 4'b0010; tick(3);
    chk_out("R6 stray ack", 1'b1, 8'h21);
    ack(); irq_pins = '0; end_irq(); tick(3);

    // R8 nesting on
    wr(2'd2, 8'h01);
    irq_pins = 4'b0001; tick(3); ack();
    irq_pins = 4'b1001; tick(3);
    chk_out("R8 higher nests", 1'b1, 8'h23);
    ack(); tick(1);
    chk_out("R8 both serviced", 1'b0, 8'h00);
    irq_pins = 4'b0010; tick(3);
    chk_out("R8 lower held", 1'b0, 8'h00);
    end_irq(); tick(1);
    chk_out("R8 equal held", 1'b0, 8'h00);
    end_irq();
    chk_out("R9 inner retire", 1'b1, 8'h21);
    ack(); irq_pins = '0; end_irq(); tick(3);
    chk_out("R8 idle", 1'b0, 8'h00);

    // R10 ack and eoi together
    irq_pins = 4'b0001; tick(3); ack();
    irq_pins = 4'b1000; tick(3);
    chk_out("R10 setup", 1'b1, 8'h23);
    int_ack = 1'b1; eoi = 1'b1; tick(1); int_ack = 1'b0; eoi = 1'b0;
    irq_pins = 4'b0000; tick(3);
    irq_pins = 4'b0001; tick(3);
    chk_out("R10 new line in service", 1'b0, 8'h00);
    end_irq();
    chk_out("R10 old line retired", 1'b1, 8'h20);
    ack(); irq_pins = '0; end_irq(); tick(3);
    wr(2'd2, 8'h00);

    // R3 edge latch, rising
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hF4);
    irq_pins = 4'b0100; tick(2);
    irq_pins = 4'b0000; tick(4);
    chk_out("R3 rising latched", 1'b1, 8'h22);
    ack(); tick(1);
    chk_out("R3 acked", 1'b0, 8'h00);
    end_irq(); tick(3);
    chk_out("R3 latch cleared", 1'b0, 8'h00);
    // R3 falling polarity
    wr(2'd0, 8'hB4);
    irq_pins = 4'b0100; tick(4);
    chk_out("R3 rising ignored", 1'b0, 8'h00);
    irq_pins = 4'b0000; tick(4);
    chk_out("R3 falling latched", 1'b1, 8'h22);
    ack(); end_irq(); tick(3);

    // R2 R11 active-low level line
    wr(2'd0, 8'hD0);
    tick(3);
    chk_out("R2 active low", 1'b1, 8'h21);
    irq_pins = 4'b0010; tick(3);
    chk_out("R2 inactive high", 1'b0, 8'h00);

    // R5 R11 vector base
    wr(2'd0, 8'hF0);
    wr(2'd3, 8'h40);
    tick(3);
    chk_out("R11 base", 1'b1, 8'h41);
    irq_pins = '0; tick(3);
    chk_out("R5 no request", 1'b0, 8'h00);

    finish_run();
  end
endmodule